// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures the frequency of an on-chip oscillator against a steady reference clock. The caller loads a cycle-count target, sets the reference-count gate and raises the meter enable. The block then counts how many reference-clock cycles pass while the monitored oscillator completes the programmed number of its own cycles. When the oscillator side reports that the count has finished, the block raises a valid flag and holds the reference-cycle total. The caller divides the target by this total and scales by the reference frequency to get the oscillator frequency.

The oscillator and reference domains exchange a start event and a done event as toggles. Each toggle crosses through a two-flop synchroniser. A bounded wait in the reference domain stops the meter from hanging when the oscillator never toggles. In that case the result reads as zero with the valid flag set. The result counter saturates rather than wrapping.

Top module: `ring_osc_freq_meter`

## Requirements
- R1: While `ref_rst` is high, and on the first reference edge after it, `result_valid` is 0 and `result_count` is 0.
- R2: A measurement returns the number of reference cycles spent while the oscillator completes `cycle_target` cycles, where a target of 0 acts as 1. With r = oscillator period / reference period and N the target, the result lies in [N·r − 2, (N+3)·r + 6].
- R3: `cycle_target` (24 bits) is captured when a measurement starts. Changing it while a measurement runs does not change that measurement's result.
- R4: A measurement starts only on a reference edge where both `meter_en` and `ref_gate_en` are 1. While `ref_gate_en` stays 0, `result_valid` stays 0 and `result_count` stays 0.
- R5: While a measurement runs, the result counter advances only on reference edges where `ref_gate_en` is 1. Lowering the gate for K cycles lowers the result by K.
- R6: Once `result_valid` is 1 and `meter_en` stays 1, `result_valid` stays 1 and `result_count` does not change, even if `cycle_target` changes.
- R7: On the first reference edge where `meter_en` is 0, `result_valid` and `result_count` become 0. Clearing takes priority over a completion that arrives in the same cycle.
- R8: The result saturates at 2^CNT_W − 1 and does not wrap.
- R9: If no done event arrives, `result_valid` rises exactly WAIT_LIMIT reference edges after the start edge, and `result_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, free running |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain; also synchronised into the oscillator domain |
| osc_clk | input | 1 | Oscillator clock being measured |
| meter_en | input | 1 | Starts a measurement when raised; clearing it stops and clears the meter |
| ref_gate_en | input | 1 | Gate on reference-cycle counting; also required to start |
| cycle_target | input | 24 | Number of oscillator cycles that define the window |
| result_valid | output | 1 | Measurement complete (or timed out) |
| result_count | output | CNT_W | Reference cycles counted, saturating; 0 on timeout |

## Verification
Three events can fall on the same reference edge: the synchronised done event, the caller clearing `meter_en`, and the bounded wait expiring. Clearing outranks completion. The bench first measures how many reference edges a short measurement takes. It then repeats the same measurement and drops the enable at several offsets around that edge. After each drop, valid and result must read zero on the next edge and stay zero once the late done toggle has crossed. The timeout path is judged by exact edge count with the oscillator stopped, and the saturation path by an exact full-scale result.

// File: rtl/ofm_pkg.sv
package ofm_pkg;
  localparam int TGT_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } meter_state_t;
endpackage

// File: rtl/ofm_sync.sv
module ofm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ofm_osc_counter.sv
module ofm_osc_counter #(
  parameter int TGT_W  = 24,
  parameter int STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             rst_async,
  input  logic             start_tgl,
  input  logic [TGT_W-1:0] tgt,
  output logic             done_tgl
);
  localparam logic [TGT_W-1:0] T_ONE = TGT_W'(1);

  logic             rst_o;
  logic             start_s;
  logic             start_seen;
  logic             busy;
  logic [TGT_W-1:0] run_cnt;
  logic [TGT_W-1:0] tgt_eff;

  ofm_sync #(.W(1), .STAGES(STAGES)) u_rst_sync (
    .clk(osc_clk), .d(rst_async), .q(rst_o)
  );

  ofm_sync #(.W(1), .STAGES(STAGES)) u_start_sync (
    .clk(osc_clk), .d(start_tgl), .q(start_s)
  );

  always_ff @(posedge osc_clk) begin
    if (rst_o) begin
      start_seen <= start_s;
      busy       <= 1'b0;
      run_cnt    <= '0;
      tgt_eff    <= T_ONE;
      done_tgl   <= 1'b0;
    end else if (start_s != start_seen) begin
      start_seen <= start_s;
      busy       <= 1'b1;
      run_cnt    <= '0;
      tgt_eff    <= (tgt == '0) ? T_ONE : tgt;
    end else if (busy) begin
      if (run_cnt + T_ONE >= tgt_eff) begin
        busy     <= 1'b0;
        run_cnt  <= '0;
        done_tgl <= ~done_tgl;
      end else begin
        run_cnt <= run_cnt + T_ONE;
      end
    end
  end

  // R2/R3: the running count never passes the captured target
  assert_busy_bound_R3: assert property (@(posedge osc_clk) disable iff (rst_o)
    busy |-> (run_cnt < tgt_eff));
endmodule

// File: rtl/ofm_ref_ctrl.sv
module ofm_ref_ctrl
  import ofm_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int WAIT_LIMIT = 1 << 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meter_en,
  input  logic             gate_en,
  input  logic [TGT_W-1:0] cycle_target,
  input  logic             done_sync,
  output logic             start_tgl,
  output logic [TGT_W-1:0] tgt_hold,
  output logic             result_valid,
  output logic [CNT_W-1:0] result_count
);
  localparam int               WAIT_W    = $clog2(WAIT_LIMIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LIMIT - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

  meter_state_t      st;
  logic              done_base;
  logic [WAIT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      start_tgl    <= 1'b0;
      done_base    <= 1'b0;
      tgt_hold     <= '0;
      wait_cnt     <= '0;
      result_valid <= 1'b0;
      result_count <= '0;
    end else if (!meter_en) begin
      st           <= ST_IDLE;
      wait_cnt     <= '0;
      result_valid <= 1'b0;
      result_count <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (gate_en) begin
            st           <= ST_RUN;
            start_tgl    <= ~start_tgl;
            done_base    <= done_sync;
            tgt_hold     <= cycle_target;
            wait_cnt     <= '0;
            result_count <= '0;
          end
        end
        ST_RUN: begin
          if (done_sync != done_base) begin
            st           <= ST_DONE;
            result_valid <= 1'b1;
          end else if (wait_cnt == WAIT_LAST) begin
            st           <= ST_DONE;
            result_valid <= 1'b1;
            result_count <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
            if (gate_en && (result_count != CNT_MAX)) begin
              result_count <= result_count + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!result_valid && (result_count == '0)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !meter_en |=> (!result_valid && (result_count == '0)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (result_valid && meter_en) |=> (result_valid && $stable(result_count)));

  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN) && !gate_en && meter_en) |=> ($stable(result_count) || result_valid));

  assert_no_start_R4: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && !gate_en) |=> !result_valid);

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    ((result_count == CNT_MAX) && meter_en && !result_valid)
      |=> ((result_count == CNT_MAX) || result_valid));
endmodule

// File: rtl/ring_osc_freq_meter.sv
module ring_osc_freq_meter
  import ofm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int WAIT_LIMIT  = 1 << 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             ref_rst,
  input  logic             osc_clk,
  input  logic             meter_en,
  input  logic             ref_gate_en,
  input  logic [TGT_W-1:0] cycle_target,
  output logic             result_valid,
  output logic [CNT_W-1:0] result_count
);
  logic             start_tgl;
  logic             done_tgl;
  logic             done_s;
  logic [TGT_W-1:0] tgt_hold;

  ofm_ref_ctrl #(.CNT_W(CNT_W), .WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
    .clk(ref_clk), .rst(ref_rst), .meter_en(meter_en), .gate_en(ref_gate_en),
    .cycle_target(cycle_target), .done_sync(done_s), .start_tgl(start_tgl),
    .tgt_hold(tgt_hold), .result_valid(result_valid), .result_count(result_count)
  );

  ofm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk(ref_clk), .d(done_tgl), .q(done_s)
  );

  ofm_osc_counter #(.TGT_W(TGT_W), .STAGES(SYNC_STAGES)) u_osc (
    .osc_clk(osc_clk), .rst_async(ref_rst), .start_tgl(start_tgl),
    .tgt(tgt_hold), .done_tgl(done_tgl)
  );
endmodule

// File: tb/test_ring_osc_freq_meter.sv
`timescale 1ns/1ps
module test_ring_osc_freq_meter;
  localparam int CNT_W = 12;
  localparam int WAIT_LIMIT = 8000;
  localparam int NVEC = 6;
  // {cycle target, oscillator half period in ps}
  localparam int VEC [NVEC][2] = '{
    '{1024, 15000}, '{64, 18500}, '{200, 50000},
    '{16, 10000}, '{1, 7000}, '{0, 12000}
  };

  logic clk = 1'b0;
  logic osc = 1'b0;
  logic rst = 1'b1;
  logic meter_en = 1'b0;
  logic gate_en = 1'b0;
  logic [23:0] cycle_target = '0;
  logic result_valid;
  logic [CNT_W-1:0] result_count;
  real osc_half_ns = 10.0;
  bit osc_on = 1'b1;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  initial begin
    forever begin
      if (osc_on) begin #(osc_half_ns) osc = ~osc; end
      else #1;
    end
  end

  ring_osc_freq_meter #(.CNT_W(CNT_W), .WAIT_LIMIT(WAIT_LIMIT)) i_ring_osc_freq_meter (
    .ref_clk(clk), .ref_rst(rst), .osc_clk(osc), .meter_en(meter_en),
    .ref_gate_en(gate_en), .cycle_target(cycle_target),
    .result_valid(result_valid), .result_count(result_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_win(input string req, input int n, input int half_ps, input int act, input int sub);
    real r;
    int lo, hi, ne;
    ne = (n == 0) ? 1 : n;
    r = 2.0 * half_ps / 20000.0;
    lo = $rtoi(ne * r) - 2 - sub;
    hi = $rtoi((ne + 3) * r + 6.0) - sub;
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!result_valid && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic start(input int n, input int half_ps);
    osc_half_ns = half_ps / 1000.0;
    cycle_target = 24'(n);
    gate_en = 1'b1;
    meter_en = 1'b1;
  endtask

  task automatic stop_and_settle();
    meter_en = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 180000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, cnt, base_lat;
    repeat (20) @(negedge clk);
    // R1: reset state
    check(!result_valid && result_count == 0, "R1 reset", result_count, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(!result_valid && result_count == 0, "R1 after reset", result_count, 0);

    // R2: table of targets and oscillator periods
    for (int i = 0; i < NVEC; i++) begin
      start(VEC[i][0], VEC[i][1]);
      wait_valid(lat);
      check(result_valid, "R2 valid", result_valid, 1);
      check_win("R2 count", VEC[i][0], VEC[i][1], int'(result_count), 0);
      stop_and_settle();
    end

    // R6: result held while enable stays high
    start(64, 18500);
    wait_valid(lat);
    cnt = int'(result_count);
    cycle_target = 24'd900;
    repeat (50) @(negedge clk);
    check(result_valid, "R6 valid held", result_valid, 1);
    check(int'(result_count) == cnt, "R6 count held", result_count, cnt);
    // R7: clearing enable clears on next edge
    meter_en = 1'b0;
    @(negedge clk);
    check(!result_valid && result_count == 0, "R7 clear", result_count, 0);
    repeat (60) @(negedge clk);

    // R4: no start with gate low
    osc_half_ns = 10.0;
    cycle_target = 24'd16;
    gate_en = 1'b0;
    meter_en = 1'b1;
    repeat (300) @(negedge clk);
    check(!result_valid && result_count == 0, "R4 no start", result_valid, 0);
    gate_en = 1'b1;
    wait_valid(lat);
    check(result_valid, "R4 start after gate", result_valid, 1);
    check_win("R4 count", 16, 10000, int'(result_count), 0);
    stop_and_settle();

    // R5: gate lowered for 300 cycles mid-run
    start(200, 50000);
    repeat (100) @(negedge clk);
    gate_en = 1'b0;
    repeat (300) @(negedge clk);
    gate_en = 1'b1;
    wait_valid(lat);
    check_win("R5 gated count", 200, 50000, int'(result_count), 300);
    stop_and_settle();

    // R3: target change mid-run ignored
    start(100, 25000);
    repeat (50) @(negedge clk);
    cycle_target = 24'd400;
    wait_valid(lat);
    check_win("R3 captured target", 100, 25000, int'(result_count), 0);
    stop_and_settle();

    // R7: clear racing completion
    start(64, 18500);
    wait_valid(base_lat);
    stop_and_settle();
    for (int off = -2; off <= 1; off++) begin
      start(64, 18500);
      repeat (base_lat + off) @(negedge clk);
      meter_en = 1'b0;
      @(negedge clk);
      check(!result_valid && result_count == 0, "R7 clear vs done", result_count, 0);
      repeat (60) @(negedge clk);
      check(!result_valid && result_count == 0, "R7 stays clear", result_valid, 0);
    end

    // R8: saturation
    start(500, 100000);
    wait_valid(lat);
    check(result_valid, "R8 valid", result_valid, 1);
    check(int'(result_count) == (1 << CNT_W) - 1, "R8 saturate", result_count, (1 << CNT_W) - 1);
    stop_and_settle();

    // R9: oscillator silent, bounded wait
    osc_on = 1'b0;
    repeat (20) @(negedge clk);
    cycle_target = 24'd64;
    gate_en = 1'b1;
    meter_en = 1'b1;
    wait_valid(lat);
    check(lat == WAIT_LIMIT + 1, "R9 timeout edge", lat, WAIT_LIMIT + 1);
    check(result_valid && result_count == 0, "R9 zero result", result_count, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule